// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the memory address of an operand from up to three terms. The terms are a base register value, an index register value shifted left by a scale, and a signed displacement. The base and the index can each be turned off. With that, the same datapath covers register-indirect, direct, base-plus-displacement, base-plus-index and the full scaled form. A second mode forms branch targets by adding the displacement to the current program counter.

Each request is one cycle long. It gives the operand values, the register numbers they came from and a use bit for each term. The address comes out of a register one cycle later, with a valid strobe. On the same edge a fault flag reports whether a register was used in a role the legality masks do not allow. The address is still formed when the fault is raised, and the consumer decides what to do with it.

Top module: `ea_gen`

## Requirements
- R1: After reset, `addr_valid`, `addr` and `sel_fault` are all zero.
- R2: `addr_valid` is high in exactly the cycle after a cycle in which `req_valid` was high, and is low otherwise.
- R3: When `pc_rel`=0 and both terms are in use, `addr` = `base_val` + (`index_val` << `scale`) + displacement. Scale codes 00, 01, 10 and 11 multiply the index by 1, 2, 4 and 8.
- R4: A term whose use bit (`base_use` or `index_use`) is 0 adds zero. This gives direct, register-indirect, base-plus-displacement and base-plus-index addresses.
- R5: When `disp_wide`=0, the displacement is `disp[7:0]` sign-extended to 32 bits, and `disp[31:8]` has no effect. When `disp_wide`=1, all 32 bits are used.
- R6: All sums wrap modulo 2^32 and no overflow indication exists.
- R7: When `pc_rel`=1, `addr` = `pc` + displacement. The base, index, scale and register numbers are ignored, and `sel_fault` is 0.
- R8: When `pc_rel`=0, `sel_fault` is 1 if a used base has a register number whose bit is 0 in `BASE_OK`, or a used index has a register number whose bit is 0 in `INDEX_OK`. By default the base may be registers 0 to 5 and the index only registers 6 and 7. The address is still formed.
- R9: In a cycle without a request, `addr` and `sel_fault` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per address |
| pc_rel | input | 1 | 1 selects the PC-relative target |
| base_use | input | 1 | Base term present |
| base_sel | input | 3 | Register number supplying the base |
| base_val | input | 32 | Base register value |
| index_use | input | 1 | Index term present |
| index_sel | input | 3 | Register number supplying the index |
| index_val | input | 32 | Index register value |
| scale | input | 2 | Left shift applied to the index |
| disp | input | 32 | Displacement or branch offset |
| disp_wide | input | 1 | 1 uses all 32 bits, 0 sign-extends the low byte |
| pc | input | 32 | Current program counter |
| addr_valid | output | 1 | Address valid, one cycle after the request |
| addr | output | 32 | Computed address |
| sel_fault | output | 1 | Illegal base or index register was used |

## Verification
The address sum and the legality check settle on the same edge from the same request. The bench therefore issues requests that name an illegal base or index together with non-trivial operands. It expects the fault flag and the full correct address together in the following cycle. PC-relative requests with illegal register numbers present on the ignored inputs check that the legality check is masked in that mode. Back-to-back requests check that each result replaces the last one without a gap.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32,
  parameter int SHORTW = 8,
  parameter int SELW = 3,
  parameter logic [(1<<SELW)-1:0] BASE_OK = 8'h3F,
  parameter logic [(1<<SELW)-1:0] INDEX_OK = 8'hC0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            pc_rel,
  input  logic            base_use,
  input  logic [SELW-1:0] base_sel,
  input  logic [AW-1:0]   base_val,
  input  logic            index_use,
  input  logic [SELW-1:0] index_sel,
  input  logic [AW-1:0]   index_val,
  input  logic [1:0]      scale,
  input  logic [AW-1:0]   disp,
  input  logic            disp_wide,
  input  logic [AW-1:0]   pc,
  output logic            addr_valid,
  output logic [AW-1:0]   addr,
  output logic            sel_fault
);
  logic [AW-1:0] disp_x, base_t, index_t, sum;
  logic          bad;

  assign disp_x  = disp_wide ? disp : {{(AW-SHORTW){disp[SHORTW-1]}}, disp[SHORTW-1:0]};
  assign base_t  = pc_rel ? pc : (base_use ? base_val : '0);
  assign index_t = (!pc_rel && index_use) ? (index_val << scale) : '0;
  assign sum     = base_t + index_t + disp_x;
  assign bad     = !pc_rel && ((base_use && !BASE_OK[base_sel]) ||
                               (index_use && !INDEX_OK[index_sel]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr       <= '0;
      sel_fault  <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        addr      <= sum;
        sel_fault <= bad;
      end
    end
  end
endmodule

module ea_gen_checks #(
  parameter int AW = 32,
  parameter int SELW = 3,
  parameter logic [(1<<SELW)-1:0] BASE_OK = 8'h3F,
  parameter logic [(1<<SELW)-1:0] INDEX_OK = 8'hC0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            pc_rel,
  input logic            base_use,
  input logic [SELW-1:0] base_sel,
  input logic            index_use,
  input logic [SELW-1:0] index_sel,
  input logic [AW-1:0]   disp,
  input logic            disp_wide,
  input logic            addr_valid,
  input logic [AW-1:0]   addr,
  input logic            sel_fault
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(addr) && $stable(sel_fault)));
  assert_pcrel_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pc_rel) |=> !sel_fault);
  assert_bad_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc_rel && base_use && !BASE_OK[base_sel]) |=> sel_fault);
  assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc_rel && index_use && !INDEX_OK[index_sel]) |=> sel_fault);
  assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc_rel && !base_use && !index_use && disp_wide) |=> (addr == $past(disp)));
endmodule

bind ea_gen ea_gen_checks #(.AW(AW), .SELW(SELW), .BASE_OK(BASE_OK), .INDEX_OK(INDEX_OK)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc_rel(pc_rel),
  .base_use(base_use), .base_sel(base_sel), .index_use(index_use),
  .index_sel(index_sel), .disp(disp), .disp_wide(disp_wide),
  .addr_valid(addr_valid), .addr(addr), .sel_fault(sel_fault));

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, pc_rel = 1'b0;
  logic        base_use = 1'b0, index_use = 1'b0, disp_wide = 1'b0;
  logic [2:0]  base_sel = '0, index_sel = '0;
  logic [1:0]  scale = '0;
  logic [31:0] base_val = '0, index_val = '0, disp = '0, pc = '0;
  logic        addr_valid, sel_fault;
  logic [31:0] addr;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc_rel(pc_rel),
    .base_use(base_use), .base_sel(base_sel), .base_val(base_val),
    .index_use(index_use), .index_sel(index_sel), .index_val(index_val),
    .scale(scale), .disp(disp), .disp_wide(disp_wide), .pc(pc),
    .addr_valid(addr_valid), .addr(addr), .sel_fault(sel_fault));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic rel, input logic bu, input logic [2:0] bs, input logic [31:0] bv,
                       input logic iu, input logic [2:0] is, input logic [31:0] iv,
                       input logic [1:0] sc, input logic [31:0] d, input logic dw);
    req_valid = 1'b1; pc_rel = rel; base_use = bu; base_sel = bs; base_val = bv;
    index_use = iu; index_sel = is; index_val = iv; scale = sc; disp = d; disp_wide = dw;
  endtask

  task automatic one(input string req, input logic rel, input logic bu, input logic [2:0] bs,
                     input logic [31:0] bv, input logic iu, input logic [2:0] is,
                     input logic [31:0] iv, input logic [1:0] sc, input logic [31:0] d,
                     input logic dw, input logic [31:0] exp_a, input logic exp_f);
    drive(rel, bu, bs, bv, iu, is, iv, sc, d, dw);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {31'b0, addr_valid}, 32'd1);
    check(req, addr, exp_a);
    check(req, {31'b0, sel_fault}, {31'b0, exp_f});
  endtask

  task automatic t_reset;
    check("R1 valid", {31'b0, addr_valid}, 32'd0);
    check("R1 addr", addr, 32'd0);
    check("R1 fault", {31'b0, sel_fault}, 32'd0);
  endtask

  task automatic t_scales;
    for (int s = 0; s < 4; s++)
      one("R3 scaled", 1'b0, 1'b1, 3'd1, 32'h1000, 1'b1, 3'd6, 32'h30, s[1:0],
          32'h0000_0100, 1'b1, 32'h1100 + (32'h30 << s), 1'b0);
  endtask

  task automatic t_reduced;
    one("R4 direct", 1'b0, 1'b0, 3'd7, 32'hDEAD, 1'b0, 3'd0, 32'hBEEF, 2'd3,
        32'h0040_0000, 1'b1, 32'h0040_0000, 1'b0);
    one("R4 indirect", 1'b0, 1'b1, 3'd4, 32'h0000_8000, 1'b0, 3'd0, 32'h55, 2'd2,
        32'h0, 1'b1, 32'h0000_8000, 1'b0);
    one("R4 base+disp", 1'b0, 1'b1, 3'd4, 32'h0000_8000, 1'b0, 3'd7, 32'h55, 2'd1,
        32'h0000_0004, 1'b0, 32'h0000_8004, 1'b0);
    one("R4 base+index", 1'b0, 1'b1, 3'd2, 32'h200, 1'b1, 3'd7, 32'h11, 2'd0,
        32'h0, 1'b1, 32'h211, 1'b0);
  endtask

  task automatic t_disp8;
    one("R5 sext neg", 1'b0, 1'b1, 3'd0, 32'h1000, 1'b0, 3'd6, 32'h0, 2'd0,
        32'h1234_5680, 1'b0, 32'h0000_0F80, 1'b0);
    one("R5 sext pos", 1'b0, 1'b1, 3'd0, 32'h1000, 1'b0, 3'd6, 32'h0, 2'd0,
        32'hFFFF_FF7F, 1'b0, 32'h0000_107F, 1'b0);
  endtask

  task automatic t_wrap;
    one("R6 wrap", 1'b0, 1'b1, 3'd3, 32'hFFFF_FFF0, 1'b1, 3'd6, 32'h8000_0000, 2'd1,
        32'h0000_0020, 1'b1, 32'h0000_0010, 1'b0);
  endtask

  task automatic t_pcrel;
    pc = 32'h0000_1000;
    one("R7 pcrel back", 1'b1, 1'b1, 3'd7, 32'hAAAA, 1'b1, 3'd1, 32'hBBBB, 2'd3,
        32'h0000_00FE, 1'b0, 32'h0000_0FFE, 1'b0);
    one("R7 pcrel wide", 1'b1, 1'b0, 3'd0, 32'h0, 1'b0, 3'd0, 32'h0, 2'd0,
        32'h0001_0000, 1'b1, 32'h0001_1000, 1'b0);
  endtask

  task automatic t_fault;
    one("R8 bad base", 1'b0, 1'b1, 3'd6, 32'h100, 1'b1, 3'd7, 32'h4, 2'd2,
        32'h8, 1'b1, 32'h118, 1'b1);
    one("R8 bad index", 1'b0, 1'b1, 3'd5, 32'h100, 1'b1, 3'd2, 32'h4, 2'd0,
        32'h0, 1'b1, 32'h104, 1'b1);
    one("R8 unused bad", 1'b0, 1'b0, 3'd6, 32'h100, 1'b0, 3'd2, 32'h4, 2'd0,
        32'h40, 1'b1, 32'h40, 1'b0);
  endtask

  task automatic t_hold;
    one("R9 setup", 1'b0, 1'b1, 3'd6, 32'h300, 1'b0, 3'd6, 32'h0, 2'd0,
        32'h3, 1'b1, 32'h303, 1'b1);
    base_val = 32'h9999; disp = 32'h7777;
    @(negedge clk);
    check("R2 idle valid", {31'b0, addr_valid}, 32'd0);
    check("R9 hold addr", addr, 32'h303);
    check("R9 hold fault", {31'b0, sel_fault}, 32'd1);
  endtask

  task automatic t_back2back;
    drive(1'b0, 1'b1, 3'd1, 32'h10, 1'b0, 3'd6, 32'h0, 2'd0, 32'h1, 1'b1);
    @(negedge clk);
    check("R2 b2b first", addr, 32'h11);
    drive(1'b0, 1'b1, 3'd7, 32'h20, 1'b1, 3'd6, 32'h2, 2'd3, 32'h2, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 b2b valid", {31'b0, addr_valid}, 32'd1);
    check("R3 b2b second", addr, 32'h32);
    check("R8 b2b fault", {31'b0, sel_fault}, 32'd1);
    @(negedge clk);
    check("R2 b2b drop", {31'b0, addr_valid}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_scales();
        t_reduced();
        t_disp8();
        t_wrap();
        t_pcrel();
        t_fault();
        t_hold();
        t_back2back();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule